// File: doc/BRIEF.md
# Reset Button Hold-Duration Counter

This block times how long an active-low push-button style reset input stays low. The input is asynchronous to the reference clock, so it is first brought through a two-flop synchronizer. While the synchronized input is low, a counter advances once per reference clock cycle (40 ns at the nominal 25 MHz). The counter saturates at its top value instead of wrapping. It keeps the measured length after the button is let go, so software can read it at its leisure through a 32-bit status word.

A write with bit 31 set clears the count. A second comparison stage holds an 8-bit threshold in whole seconds. It raises a registered, sticky long-press flag once the count reaches `TICKS_PER_SEC × threshold`. A platform uses this flag to recognise a factory-reset request.

The control core is a four-state machine:
- **IDLE**: input released, count zero.
- **TIMING**: input held, counting.
- **SATURATED**: input held, count pinned at its maximum.
- **HOLD**: input released, count retained.

Its transitions are:
- IDLE→TIMING on a press.
- TIMING→SATURATED when the count reaches its maximum.
- TIMING→HOLD and SATURATED→HOLD on release.
- HOLD→TIMING on a new press, which restarts the count at one.
- Any state goes to TIMING or IDLE on a clear, depending on the input level.

Top module: `rsthold_counter`

## Requirements
- R1: While the synchronized input is low, the count rises by exactly one per reference clock cycle; a press lasting L cycles (below saturation) leaves a count of L.
- R2: The input passes through a two-flop synchronizer: after the input falls, the count is still 0 following the second rising edge and reads 1 following the third.
- R3: The count saturates at 2^CNT_W−1 and never wraps while the input stays low.
- R4: The status word carries the count in bits CNT_W−1:0; every bit above reads 0 (bits 31:29 with default parameters).
- R5: A write (`reg_wr` high) whose bit 31 is 1 clears the count to zero; a write with bit 31 at 0 has no effect.
- R6: A clear arriving in the same cycle as an increment wins; counting resumes from zero on the following cycles if the input is still low.
- R7: After the input returns high, the count keeps its value until cleared.
- R8: A new press after a release restarts the count from zero, with no clear needed.
- R9: With a non-zero threshold T, `long_press` becomes 1 one cycle after the count reaches TICKS_PER_SEC×T, and not below it.
- R10: A threshold of zero never sets `long_press`.
- R11: Once set, `long_press` stays 1 until a clear, even if the threshold changes or a new press restarts the count.
- R12: After reset the count is 0, `long_press` is 0 and the machine is in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (nominally 25 MHz) |
| rst_n | input | 1 | Active-low block reset, synchronous to clk |
| press_n | input | 1 | Asynchronous active-low input whose low time is measured |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 32 | Write data; bit 31 requests a clear |
| reg_rdata | output | 32 | Status word: count in low bits, zeros above |
| thr_sec | input | 8 | Long-press threshold in whole seconds, 0 disables |
| long_press | output | 1 | Sticky long-press flag |

## Verification
The assertions check these properties on every cycle:
- the single-step increment during a held press;
- the pinned value at saturation;
- the frozen count while the input is high;
- the clear's effect on count and flag;
- the zeroed upper status bits;
- the flag's stickiness and its silence under a zero threshold.

Some behaviours only the bench scenarios can show:
- the two-cycle synchronizer latency;
- that a whole press of L cycles yields exactly L;
- the restart after release;
- clear-beats-increment at a chosen cycle;
- the exact count at which the flag first appears.

The bench covers these with reduced counter width and ticks-per-second, using directed cases and random press lengths and thresholds.

// File: rtl/rsthold_pkg.sv
package rsthold_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_TIMING    = 2'd1,
        ST_SATURATED = 2'd2,
        ST_HOLD      = 2'd3
    } hold_state_t;
endpackage

// File: rtl/rsthold_sync.sv
module rsthold_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/rsthold_fsm.sv
module rsthold_fsm
    import rsthold_pkg::*;
#(
    parameter int CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             press_low,
    input  logic             clr,
    output logic [CNT_W-1:0] count,
    output hold_state_t      state
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_MAX - CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    hold_state_t      state_nx;
    logic [CNT_W-1:0] count_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            count <= '0;
        end else begin
            state <= state_nx;
            count <= count_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (press_low) state_nx = ST_TIMING;
            ST_TIMING: begin
                if (!press_low)             state_nx = ST_HOLD;
                else if (count == CNT_LAST) state_nx = ST_SATURATED;
            end
            ST_SATURATED: if (!press_low) state_nx = ST_HOLD;
            ST_HOLD:      if (press_low) state_nx = ST_TIMING;
            default:      state_nx = ST_IDLE;
        endcase
        if (clr) state_nx = press_low ? ST_TIMING : ST_IDLE;
    end

    // count output logic
    always_comb begin
        count_nx = count;
        unique case (state)
            ST_IDLE:      if (press_low) count_nx = CNT_ONE;
            ST_TIMING:    if (press_low) count_nx = count + CNT_ONE;
            ST_SATURATED: count_nx = count;
            ST_HOLD:      if (press_low) count_nx = CNT_ONE;
            default:      count_nx = '0;
        endcase
        if (clr) count_nx = '0;
    end
endmodule

// File: rtl/rsthold_thresh.sv
module rsthold_thresh #(
    parameter int CNT_W         = 29,
    parameter int THR_W         = 8,
    parameter int TICKS_PER_SEC = 25_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] count,
    input  logic [THR_W-1:0] thr_sec,
    output logic             long_press
);
    localparam int LIM_W = 64;

    logic [LIM_W-1:0] limit;
    logic             reached;

    assign limit   = LIM_W'(TICKS_PER_SEC) * LIM_W'(thr_sec);
    assign reached = (thr_sec != '0) && (LIM_W'(count) >= limit);

    always_ff @(posedge clk) begin
        if (!rst_n)       long_press <= 1'b0;
        else if (clr)     long_press <= 1'b0;
        else if (reached) long_press <= 1'b1;
    end
endmodule

// File: rtl/rsthold_counter.sv
module rsthold_counter
    import rsthold_pkg::*;
#(
    parameter int CNT_W         = 29,
    parameter int THR_W         = 8,
    parameter int REG_W         = 32,
    parameter int CLR_BIT       = 31,
    parameter int SYNC_STAGES   = 2,
    parameter int TICKS_PER_SEC = 25_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             press_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [THR_W-1:0] thr_sec,
    output logic             long_press
);
    logic             press_s;
    logic             press_low;
    logic             clr_req;
    logic [CNT_W-1:0] count;
    hold_state_t      state;

    rsthold_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (press_n),
        .sync_out (press_s)
    );

    assign press_low = ~press_s;
    assign clr_req   = reg_wr & reg_wdata[CLR_BIT];

    rsthold_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .press_low (press_low),
        .clr       (clr_req),
        .count     (count),
        .state     (state)
    );

    rsthold_thresh #(
        .CNT_W         (CNT_W),
        .THR_W         (THR_W),
        .TICKS_PER_SEC (TICKS_PER_SEC)
    ) u_thr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr_req),
        .count      (count),
        .thr_sec    (thr_sec),
        .long_press (long_press)
    );

    always_comb begin
        reg_rdata             = '0;
        reg_rdata[CNT_W-1:0]  = count;
    end
endmodule

// File: rtl/rsthold_checker.sv
module rsthold_checker #(
    parameter int CNT_W = 29,
    parameter int THR_W = 8,
    parameter int REG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             press_low,
    input logic             clr,
    input logic [CNT_W-1:0] count,
    input logic [THR_W-1:0] thr_sec,
    input logic             long_press,
    input logic [REG_W-1:0] rdata
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (press_low && $past(press_low) && !clr && count != CNT_MAX)
        |=> count == $past(count) + CNT_W'(1));

    p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (press_low && $past(press_low) && !clr && count == CNT_MAX)
        |=> count == CNT_MAX);

    p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata >> CNT_W) == '0);

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0) && !long_press);

    p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!press_low && !clr) |=> $stable(count));

    p_thr_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_sec == '0 && !long_press && !clr) |=> !long_press);

    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (long_press && !clr) |=> long_press);
endmodule

bind rsthold_counter rsthold_checker #(
    .CNT_W (CNT_W),
    .THR_W (THR_W),
    .REG_W (REG_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .press_low  (press_low),
    .clr        (clr_req),
    .count      (count),
    .thr_sec    (thr_sec),
    .long_press (long_press),
    .rdata      (reg_rdata)
);

// File: tb/tb_rsthold_counter.sv
module tb_rsthold_counter;
    localparam int CNT_W = 8;
    localparam int TICKS = 10;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        press_n = 1'b1;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  thr_sec = '0;
    logic        long_press;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    rsthold_counter #(.CNT_W(CNT_W), .TICKS_PER_SEC(TICKS)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .press_n    (press_n),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .thr_sec    (thr_sec),
        .long_press (long_press)
    );

    function automatic int exp_count(int len);
        return (len > CMAX) ? CMAX : len;
    endfunction

    function automatic bit exp_flag(int cnt, int thr);
        return (thr != 0) && (cnt >= TICKS * thr);
    endfunction

    task automatic check(string req, int actual, int expected);
        n_tests++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic press(int len);
        @(negedge clk) press_n = 1'b0;
        repeat (len) @(negedge clk);
        press_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic reg_write(logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 count", int'(reg_rdata), 0);
        check("R12 flag", int'(long_press), 0);

        // R2 synchronizer latency
        @(negedge clk) press_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R2 after 2 edges", int'(reg_rdata), 0);
        @(negedge clk);
        check("R2 after 3 edges", int'(reg_rdata), 1);
        press_n = 1'b1;
        repeat (4) @(negedge clk);
        reg_write(32'h8000_0000);
        check("R5 clear", int'(reg_rdata), 0);

        // R1 exact length, R7 retained
        press(5);
        check("R1 len5", int'(reg_rdata), 5);
        repeat (20) @(negedge clk);
        check("R7 retained", int'(reg_rdata), 5);

        // R8 restart without clear
        press(7);
        check("R8 restart", int'(reg_rdata), 7);

        // R5 write without bit 31 ignored
        reg_write(32'h7FFF_FFFF);
        check("R5 ignored write", int'(reg_rdata), 7);
        reg_write(32'h8000_0000);
        check("R5 clear2", int'(reg_rdata), 0);

        // R3 saturation, R4 upper bits
        press(300);
        check("R3 saturate", int'(reg_rdata[CNT_W-1:0]), CMAX);
        check("R4 upper zero", int'(reg_rdata[31:CNT_W]), 0);
        reg_write(32'h8000_0000);

        // R6 clear during press
        @(negedge clk) press_n = 1'b0;
        repeat (19) @(negedge clk);
        reg_wr = 1'b1; reg_wdata = 32'h8000_0000;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
        check("R6 clear wins", int'(reg_rdata), 0);
        repeat (5) @(negedge clk);
        check("R6 resumes", int'(reg_rdata), 5);
        press_n = 1'b1;
        repeat (4) @(negedge clk);
        reg_write(32'h8000_0000);

        // R10 zero threshold
        thr_sec = 8'd0;
        press(200);
        check("R10 thr zero", int'(long_press), 0);
        reg_write(32'h8000_0000);

        // R9 boundary
        thr_sec = 8'd3;
        press(29);
        check("R9 below", int'(long_press), 0);
        reg_write(32'h8000_0000);
        @(negedge clk) press_n = 1'b0;
        repeat (32) @(negedge clk);
        check("R9 not yet", int'(long_press), 0);
        @(negedge clk);
        check("R9 one cycle later", int'(long_press), 1);
        press_n = 1'b1;
        repeat (4) @(negedge clk);

        // R11 sticky
        thr_sec = 8'd0;
        press(5);
        check("R11 sticky", int'(long_press), 1);
        reg_write(32'h8000_0000);
        check("R11 cleared", int'(long_press), 0);

        // random presses
        for (int i = 0; i < 25; i++) begin
            int len;
            int thr;
            len = 1 + int'($urandom % 300);
            thr = int'($urandom % 5);
            thr_sec = 8'(thr);
            press(len);
            check("R1 random count", int'(reg_rdata), exp_count(len));
            check("R9 random flag", int'(long_press),
                  int'(exp_flag(exp_count(len), thr)));
            reg_write(32'h8000_0000);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule